// File: doc/BRIEF.md
# Zero-Skipping Dual-Modulus Clock Prescaler

This block divides its input clock by 16 or by 15. A four-bit phase register counts up by one on every input clock edge. When it reaches its top value it wraps. The modulus input decides where it wraps to: back to zero for a full 16-state pass, or straight to one for a 15-state pass that skips zero. No extra counting stage is involved; the shorter ratio comes only from leaving out one state.

The block is meant to be the first divider behind an oscillator in an integer-N loop. A program counter and a swallow counter downstream drive the modulus line. Each pass produces one single-cycle `tick`. It also produces a registered slow clock, which is the most significant phase bit and is high for the second half of the pass. The modulus line is only looked at on the wrap edge. Changes made part way through a pass therefore never produce a period of some intermediate length.

Top module: `dmp_prescaler`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `phase` = 0, `tick` = 0 and `slow_clk` = 0 (synchronous reset).
- R2: If `mod_short` is 0 at the wrap edge (the edge where `phase` leaves 15), `phase` goes to 0. The next `tick` then follows 16 input cycles later.
- R3: If `mod_short` is 1 at the wrap edge, `phase` goes to 1. The next `tick` then follows 15 input cycles later, and `phase` is never 0 during that pass.
- R4: Changes of `mod_short` at any edge other than the wrap edge have no effect on the length of the current pass.
- R5: `tick` is high for exactly one input cycle per pass: the cycle right after the wrap edge.
- R6: `slow_clk` equals bit 3 of `phase`, so it is high for exactly 8 input cycles per pass in both modes.
- R7: After reset is released, `phase` counts 1, 2, … on successive edges. The first `tick` appears after the 16th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| mod_short | input | 1 | 1 selects divide-by-15 (skip zero), 0 selects divide-by-16; sampled at the wrap edge |
| tick | output | 1 | One-cycle pulse marking the start of each pass |
| slow_clk | output | 1 | Divided clock, the phase MSB |
| phase | output | 4 | Current state of the counter |

## Verification
The assertions check the edge-by-edge structure on every cycle. Outside the wrap, the phase goes up by exactly one. At the wrap, it goes to 0 or to 1 according to the modulus. Reset forces zero, and every wrap produces a tick that lasts one cycle. Only the bench scenarios can show the properties that span a whole pass. These are the tick-to-tick period of 15 or 16 cycles, and its immunity to toggling of the modulus in the middle of a pass. They also cover the eight-cycle high time of the slow clock, the absence of zero in short passes, and the 16-cycle delay to the first tick after reset.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  typedef enum logic {MOD_FULL = 1'b0, MOD_SHORT = 1'b1} mod_e;

  // Pass length in input cycles for a counter of w bits
  function automatic int unsigned pass_len(input int unsigned w, input logic short_mode);
    return (32'd1 << w) - (short_mode ? 32'd1 : 32'd0);
  endfunction

  // Re-entry state after the wrap: zero, or one when zero is skipped
  function automatic logic wrap_entry_lsb(input mod_e m);
    return (m == MOD_SHORT);
  endfunction
endpackage

// File: rtl/dmp_step.sv
module dmp_step #(
  parameter int unsigned PH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            short_sel,
  output logic [PH_W-1:0] phase,
  output logic            at_wrap
);
  import dmp_pkg::*;
  localparam logic [PH_W-1:0] LAST = '1;
  localparam logic [PH_W-1:0] ONE  = {{(PH_W-1){1'b0}}, 1'b1};

  logic [PH_W-1:0] phase_nxt;
  logic [PH_W-1:0] incr;
  mod_e            mode;

  assign mode    = short_sel ? MOD_SHORT : MOD_FULL;
  assign at_wrap = (phase == LAST);
  assign incr    = phase + ONE;

  always_comb begin
    if (at_wrap) begin
      phase_nxt = '0;
      phase_nxt[0] = wrap_entry_lsb(mode);
    end else begin
      phase_nxt = incr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase_nxt;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> phase == '0);
  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !at_wrap |=> phase == $past(phase) + ONE);
  // R2
  full_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (at_wrap && !short_sel) |=> phase == '0);
  // R3
  zero_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (at_wrap && short_sel) |=> phase == ONE);
endmodule

// File: rtl/dmp_mark.sv
module dmp_mark (
  input  logic clk,
  input  logic rst,
  input  logic at_wrap,
  output logic tick
);
  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= at_wrap;
  end

  // R5
  tick_width_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
  // R5
  tick_source_chk: assert property (@(posedge clk) disable iff (rst) at_wrap |=> tick);
  // R1
  reset_tick_chk: assert property (@(posedge clk) rst |=> !tick);
endmodule

// File: rtl/dmp_prescaler.sv
module dmp_prescaler #(
  parameter int unsigned PH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mod_short,
  output logic            tick,
  output logic            slow_clk,
  output logic [PH_W-1:0] phase
);
  logic wrap_evt;

  dmp_step #(.PH_W(PH_W)) u_step (
    .clk(clk), .rst(rst), .short_sel(mod_short),
    .phase(phase), .at_wrap(wrap_evt)
  );

  dmp_mark u_mark (
    .clk(clk), .rst(rst), .at_wrap(wrap_evt), .tick(tick)
  );

  assign slow_clk = phase[PH_W-1];

  // R6
  slow_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(slow_clk) |-> !tick);
endmodule

// File: tb/dmp_prescaler_test.sv
module dmp_prescaler_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mod_short = 1'b0;
  logic       tick;
  logic       slow_clk;
  logic [3:0] phase;

  int checks = 0, fails = 0;
  int cyc = 0, last_tick = 0, exp_len = 16, hi_cnt = 0;
  bit first_pending = 1, cur_short = 0, saw_zero = 0, changed = 0, prev_tick = 0, done = 0;

  always #2 clk = ~clk;

  dmp_prescaler uut (.clk(clk), .rst(rst), .mod_short(mod_short),
                     .tick(tick), .slow_clk(slow_clk), .phase(phase));

  function automatic int want_len(input bit s);
    return s ? 15 : 16;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic observe();
    cyc++;
    if (tick && prev_tick) chk(0, "R5 tick width", 2, 1);
    if (slow_clk) hi_cnt++;
    if (phase == 4'd0 && !tick) saw_zero = 1;
    if (tick) begin
      if (first_pending) begin
        chk(cyc == 16, "R7 first tick", cyc, 16);
        first_pending = 0;
      end else begin
        chk(cyc - last_tick == exp_len, changed ? "R4 mid-pass change" : (cur_short ? "R3 period" : "R2 period"),
            cyc - last_tick, exp_len);
        chk(hi_cnt == 8, "R6 slow high", hi_cnt, 8);
        if (cur_short) chk(!saw_zero, "R3 zero skipped", int'(saw_zero), 0);
      end
      chk(phase == (mod_short ? 4'd1 : 4'd0), mod_short ? "R3 entry" : "R2 entry",
          int'(phase), mod_short ? 1 : 0);
      cur_short = mod_short;
      exp_len = want_len(mod_short);
      last_tick = cyc; hi_cnt = 0; saw_zero = 0; changed = 0;
    end
    prev_tick = tick;
  endtask

  task automatic step(input bit m);
    @(negedge clk);
    observe();
    if (m != mod_short) changed = 1;
    mod_short = m;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(phase == 4'd0, "R1 phase", int'(phase), 0);
    chk(tick == 1'b0, "R1 tick", int'(tick), 0);
    chk(slow_clk == 1'b0, "R1 slow", int'(slow_clk), 0);
    rst = 1'b0;
    cyc = 0; first_pending = 1; hi_cnt = 0; prev_tick = 0; changed = 0; saw_zero = 0;
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'd20240);
    do_reset();
    repeat (80) step(1'b0);
    repeat (80) step(1'b1);
    for (int i = 0; i < 160; i++) step(i[0]);
    do_reset();
    repeat (40) step(1'b1);
    for (int i = 0; i < 3000; i++) begin
      r = $urandom();
      step(r[0] ^ (r[5:1] == 5'd0 ? mod_short : 1'b0));
    end
    repeat (40) step(1'b0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule